// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies data by walking a chain of descriptors held in memory. Software writes the address of the first descriptor into a register and sets the run bit. The channel then reads the four-word descriptor and moves the number of bytes it names from a source address to a target address, one beat at a time. It then follows the descriptor's link to the next one, until it meets a link marked as the end of the chain. A chain whose last link points back to its first descriptor runs in a loop until software clears the run bit.

Each descriptor's command word sets the beat width, the burst size, whether each address advances, whether the transfer is paced by a peripheral, and whether completion raises the interrupt. Paced transfers wait for a peripheral request line before each burst and answer with a one-cycle acknowledge when the burst is done. A small register interface gives run control, sticky completion and bus-error flags, and read-only views of the stopped state, the peripheral request and the live source and target addresses. Memory is reached through a single word-wide request/grant port whose read data and error response are valid in the grant cycle.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset the run bit, both sticky flags, `irq`, `mem_req` and `periph_ack` are 0, and the status word (register 0) reads 0x0000_0008: only the stopped bit (bit 3) is set.
- R2: Starting from the descriptor address, the channel reads four words at +0, +4, +8 and +12, taken as link, source, target and command. It issues no data access until the fourth word has been granted.
- R3: Command bits 12:0 give the byte count. Bits 14:13 give the beat width (1 = one byte, 2 = two bytes, otherwise four). Each beat reads the word at the current source and writes it unchanged to the current target, and the count drops by the width.
- R4: Command bit 21 makes the source advance by the width after each beat, and bit 20 does the same for the target. An address whose bit is clear stays fixed.
- R5: When command bit 18 or bit 19 selects peripheral pacing, each burst starts only while `periph_req` is high. Bits 16:15 give the burst length (1 = 8 bytes, 2 = 16 bytes, otherwise 32). `periph_ack` pulses for one cycle after the last write of each burst.
- R6: A link word with bit 0 set ends the chain: after that descriptor the run bit clears and the stopped bit reads 1. Any other link is fetched next.
- R7: Command bit 17 sets the completion flag (status bit 0) and `irq` when its descriptor finishes. Writing 1 to status bit 0 clears the flag; writing 0 leaves it unchanged.
- R8: Writing status bit 31 sets or clears the run bit. Clearing it stops the channel at the next beat or burst boundary with no further memory access. Status bit 3 (stopped) and bit 8 (peripheral request level) are read-only.
- R9: Registers 2 and 3 return the current source and target addresses while a transfer is in progress. Register 1 holds the first descriptor address.
- R10: A granted access with `mem_err` high sets the bus-error flag (status bit 1, cleared by writing 1), raises `irq`, clears the run bit and stops the channel without writing.
- R11: A chain whose last link points to its own first descriptor repeats indefinitely: the stopped bit stays 0 until software clears the run bit.
- R12: A descriptor with a byte count of 0 completes after its fetch with no data access, and still honours its interrupt bit and link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 status/control, 1 first descriptor, 2 source, 3 target |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Channel interrupt (completion or bus-error flag set) |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 2 | Beat size: 0 one byte, 1 two bytes, 2 four bytes |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_err | input | 1 | Error response, valid with the grant |
| periph_req | input | 1 | Peripheral ready for a burst |
| periph_ack | output | 1 | One-cycle pulse at the end of a paced burst |

## Verification
The bench stalls grants pseudo-randomly and compares every write against a queue of expected address/data pairs. A channel that started moving data before the fourth descriptor word, or that misread the word order, shows up as a wrong first data read or a stray write. Paced transfers are held with the request low to catch a channel that ignores pacing. The acknowledge count and the mid-chain target address expose wrong burst lengths or width steps. The bench also clears the run bit in mid-transfer, injects an error on a source read, and runs a self-looping chain: a design that overruns the stop, writes after an error, or halts a cyclic chain at its link shows up as extra writes, a wrong flag pattern or a premature stopped bit. A zero-length descriptor checks that no data access is made when the count is already exhausted.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_DONE
  } chan_state_t;

  // command word field positions
  localparam int CMD_WIDTH_LSB = 13;
  localparam int CMD_BURST_LSB = 15;
  localparam int CMD_END_IRQ   = 17;
  localparam int CMD_FLOW_SRC  = 18;
  localparam int CMD_FLOW_TGT  = 19;
  localparam int CMD_INC_TGT   = 20;
  localparam int CMD_INC_SRC   = 21;

  // status word bit positions
  localparam int ST_BIT_END  = 0;
  localparam int ST_BIT_ERR  = 1;
  localparam int ST_BIT_STOP = 3;
  localparam int ST_BIT_REQ  = 8;
  localparam int ST_BIT_RUN  = 31;

  typedef struct packed {
    logic       inc_src;
    logic       inc_tgt;
    logic       paced;
    logic       end_irq;
    logic [1:0] burst;
    logic [1:0] width;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.inc_src = w[CMD_INC_SRC];
    c.inc_tgt = w[CMD_INC_TGT];
    c.paced   = w[CMD_FLOW_SRC] | w[CMD_FLOW_TGT];
    c.end_irq = w[CMD_END_IRQ];
    c.burst   = w[CMD_BURST_LSB +: 2];
    c.width   = w[CMD_WIDTH_LSB +: 2];
    return c;
  endfunction

  function automatic logic [5:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 6'd1;
      2'd2:    return 6'd2;
      default: return 6'd4;
    endcase
  endfunction

  function automatic logic [5:0] burst_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 6'd8;
      2'd2:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              periph_req,
  input  logic              idle,
  input  logic [ADDR_W-1:0] cur_src,
  input  logic [ADDR_W-1:0] cur_tgt,
  input  logic              set_end,
  input  logic              set_err,
  input  logic              stop_req,
  output logic              run,
  output logic [ADDR_W-1:0] first_desc,
  output logic              irq
);

  logic run_q, flag_end, flag_err;
  logic [ADDR_W-1:0] first_q;
  logic [31:0] rdata_q;
  logic [31:0] status;
  logic ctl_wr;

  assign ctl_wr = we && (addr == 2'd0);

  always_comb begin
    status = '0;
    status[ST_BIT_RUN]  = run_q;
    status[ST_BIT_REQ]  = periph_req;
    status[ST_BIT_STOP] = idle;
    status[ST_BIT_ERR]  = flag_err;
    status[ST_BIT_END]  = flag_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      flag_end <= 1'b0;
      flag_err <= 1'b0;
      first_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (stop_req || set_err) run_q <= 1'b0;
      if (ctl_wr) run_q <= wdata[ST_BIT_RUN];
      if (ctl_wr && wdata[ST_BIT_END]) flag_end <= 1'b0;
      if (set_end) flag_end <= 1'b1;
      if (ctl_wr && wdata[ST_BIT_ERR]) flag_err <= 1'b0;
      if (set_err) flag_err <= 1'b1;
      if (we && addr == 2'd1) first_q <= wdata[ADDR_W-1:0];
      case (addr)
        2'd0:    rdata_q <= status;
        2'd1:    rdata_q <= 32'(first_q);
        2'd2:    rdata_q <= 32'(cur_src);
        default: rdata_q <= 32'(cur_tgt);
      endcase
    end
  end

  assign run        = run_q;
  assign first_desc = first_q;
  assign rdata      = rdata_q;
  assign irq        = flag_end | flag_err;

  AST_ERR_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (set_err && !ctl_wr) |=> (flag_err && !run_q)) else $error("error did not stop run"); // R10

  AST_END_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_end && !ctl_wr) |=> flag_end) else $error("completion flag lost"); // R7

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [ADDR_W-1:0] first_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [1:0]        mem_size,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic              periph_req,
  output logic              periph_ack,
  output logic              set_end,
  output logic              set_err,
  output logic              stop_req,
  output logic              idle,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_tgt
);

  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  chan_state_t       state;
  logic [IDX_W-1:0]  fidx;
  logic [ADDR_W-1:0] fetch_base, link_q, src_q, tgt_q;
  cmd_t              cmd_q, cmd_new;
  logic [LEN_W-1:0]  len_left, len_next, len_new;
  logic [5:0]        burst_left, burst_next, step;
  logic [31:0]       data_q;
  logic              ack_q;
  logic              granted_ok;

  assign cmd_new    = decode_cmd(mem_rdata);
  assign len_new    = mem_rdata[LEN_W-1:0];
  assign step       = width_bytes(cmd_q.width);
  assign granted_ok = mem_gnt && !mem_err;

  always_comb begin
    if (len_left <= LEN_W'(step)) len_next = '0;
    else                          len_next = len_left - LEN_W'(step);
    if (burst_left <= step) burst_next = '0;
    else                    burst_next = burst_left - step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      fidx       <= '0;
      fetch_base <= '0;
      link_q     <= '0;
      src_q      <= '0;
      tgt_q      <= '0;
      cmd_q      <= '0;
      len_left   <= '0;
      burst_left <= '0;
      data_q     <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run) begin
            fetch_base <= first_desc;
            fidx       <= '0;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_gnt) begin
            if (mem_err) begin
              state <= ST_IDLE;
            end else begin
              fidx <= fidx + 1'b1;
              case (fidx)
                2'd0: link_q <= mem_rdata[ADDR_W-1:0];
                2'd1: src_q  <= mem_rdata[ADDR_W-1:0];
                2'd2: tgt_q  <= mem_rdata[ADDR_W-1:0];
                default: begin
                  cmd_q      <= cmd_new;
                  len_left   <= len_new;
                  burst_left <= burst_bytes(cmd_new.burst);
                  if (!run)               state <= ST_IDLE;
                  else if (len_new == '0) state <= ST_DONE;
                  else if (cmd_new.paced) state <= ST_WAIT;
                  else                    state <= ST_RD;
                end
              endcase
            end
          end
        end
        ST_WAIT: begin
          if (!run) begin
            state <= ST_IDLE;
          end else if (periph_req) begin
            burst_left <= burst_bytes(cmd_q.burst);
            state      <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_gnt) begin
            if (mem_err) state <= ST_IDLE;
            else begin
              data_q <= mem_rdata;
              state  <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_gnt) begin
            if (mem_err) begin
              state <= ST_IDLE;
            end else begin
              if (cmd_q.inc_src) src_q <= src_q + ADDR_W'(step);
              if (cmd_q.inc_tgt) tgt_q <= tgt_q + ADDR_W'(step);
              len_left   <= len_next;
              burst_left <= burst_next;
              if (len_next == '0) begin
                ack_q <= cmd_q.paced;
                state <= ST_DONE;
              end else if (!run) begin
                state <= ST_IDLE;
              end else if (burst_next == '0) begin
                ack_q <= cmd_q.paced;
                if (cmd_q.paced) state <= ST_WAIT;
                else begin
                  burst_left <= burst_bytes(cmd_q.burst);
                  state      <= ST_RD;
                end
              end else begin
                state <= ST_RD;
              end
            end
          end
        end
        ST_DONE: begin
          if (!run || link_q[0]) begin
            state <= ST_IDLE;
          end else begin
            fetch_base <= link_q;
            fidx       <= '0;
            state      <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (state == ST_FETCH) || (state == ST_RD) || (state == ST_WR);
    mem_we   = (state == ST_WR);
    mem_size = (state == ST_FETCH) ? 2'd2 : size_code(cmd_q.width);
    case (state)
      ST_FETCH: mem_addr = fetch_base + ADDR_W'({fidx, 2'b00});
      ST_WR:    mem_addr = tgt_q;
      default:  mem_addr = src_q;
    endcase
  end

  assign mem_wdata  = data_q;
  assign periph_ack = ack_q;
  assign set_err    = mem_req && mem_gnt && mem_err;
  assign set_end    = (state == ST_DONE) && cmd_q.end_irq;
  assign stop_req   = (state == ST_DONE) && run && link_q[0];
  assign idle       = (state == ST_IDLE);
  assign cur_src    = src_q;
  assign cur_tgt    = tgt_q;

  AST_FETCH_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && granted_ok && fidx != 2'd3)
      |=> (state == ST_FETCH && mem_addr == $past(mem_addr) + ADDR_W'(4))) else $error("fetch order"); // R2

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && granted_ok && !cmd_q.inc_src) |=> (src_q == $past(src_q))) else $error("source moved"); // R4

  AST_COUNT_FALLS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && granted_ok) |=> (len_left < $past(len_left))) else $error("count did not fall"); // R3

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    periph_ack |=> !periph_ack) else $error("ack longer than one cycle"); // R5

  AST_STOP_MARKER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && link_q[0]) |=> (state == ST_IDLE)) else $error("ran past stop marker"); // R6

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [1:0]        mem_size,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic              periph_req,
  output logic              periph_ack
);

  logic              run, idle, set_end, set_err, stop_req;
  logic [ADDR_W-1:0] first_desc, cur_src, cur_tgt;

  dma_chain_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .we         (csr_we),
    .addr       (csr_addr),
    .wdata      (csr_wdata),
    .rdata      (csr_rdata),
    .periph_req (periph_req),
    .idle       (idle),
    .cur_src    (cur_src),
    .cur_tgt    (cur_tgt),
    .set_end    (set_end),
    .set_err    (set_err),
    .stop_req   (stop_req),
    .run        (run),
    .first_desc (first_desc),
    .irq        (irq)
  );

  dma_chain_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .first_desc (first_desc),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_size   (mem_size),
    .mem_rdata  (mem_rdata),
    .mem_gnt    (mem_gnt),
    .mem_err    (mem_err),
    .periph_req (periph_req),
    .periph_ack (periph_ack),
    .set_end    (set_end),
    .set_err    (set_err),
    .stop_req   (stop_req),
    .idle       (idle),
    .cur_src    (cur_src),
    .cur_tgt    (cur_tgt)
  );

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (idle && !run) |=> (!mem_req || run)) else $error("access while stopped"); // R8

endmodule

// File: tb/dma_chain_channel_bench.sv
module dma_chain_channel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, mem_req, mem_we, mem_gnt, mem_err, periph_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        periph_req = 1'b0;

  always #5 clk = ~clk;

  dma_chain_channel u_dma_chain_channel (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata),
    .mem_gnt(mem_gnt), .mem_err(mem_err), .periph_req(periph_req),
    .periph_ack(periph_ack)
  );

  // memory model: 256 words, grants stalled by an LFSR
  logic [31:0] mem [0:255];
  logic [4:0]  lf;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always @(posedge clk) begin
    if (rst) lf <= 5'h1F;
    else     lf <= {lf[3:0], lf[4] ^ lf[2]};
    if (mem_req && mem_gnt && mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
  end

  assign mem_gnt   = mem_req && (lf[0] | lf[3]);
  assign mem_err   = mem_gnt && err_en && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[9:2]];

  int nchk = 0;
  int nerr = 0;
  int wr_count = 0;
  int ack_cnt = 0;
  bit sb_strict = 1'b1;
  logic [31:0] last_wr_addr, last_wr_data;
  logic [63:0] exp_q[$];
  logic [31:0] rd_log[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_gnt) begin
        if (!mem_we) rd_log.push_back(mem_addr);
        else begin
          wr_count++;
          last_wr_addr = mem_addr;
          last_wr_data = mem_wdata;
          if (exp_q.size() > 0) begin
            logic [63:0] it;
            it = exp_q.pop_front();
            chk("R3 write addr", mem_addr, it[63:32]);
            chk("R3 write data", mem_wdata, it[31:0]);
          end else if (sb_strict) begin
            chk("R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
          end
        end
      end
      if (periph_ack) ack_cnt++;
    end
  end

  function automatic logic [31:0] mk_cmd(input int len, input int wc, input int bc,
      input bit irqen, input bit paced, input bit itgt, input bit isrc);
    logic [31:0] c;
    c = 32'(len) & 32'h1FFF;
    c[14:13] = 2'(wc);
    c[16:15] = 2'(bc);
    c[17] = irqen;
    c[18] = paced;
    c[20] = itgt;
    c[21] = isrc;
    return c;
  endfunction

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return 32'hC0DE_0000 + {24'd0, a[9:2]};
  endfunction

  task automatic set_desc(input logic [31:0] base, input logic [31:0] nxt,
      input logic [31:0] s, input logic [31:0] t, input logic [31:0] c);
    mem[base[9:2]]     = nxt;
    mem[base[9:2] + 1] = s;
    mem[base[9:2] + 2] = t;
    mem[base[9:2] + 3] = c;
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic start(input logic [31:0] desc);
    csr_wr(2'd0, 32'h3);
    csr_wr(2'd1, desc);
    csr_wr(2'd0, 32'h8000_0000);
  endtask

  task automatic wait_stopped(output logic [31:0] s);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      csr_rd(2'd0, s);
      if (s[3]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired (R1..R12 run incomplete) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int wbase, abase;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    csr_rd(2'd0, s);
    chk("R1 status after reset", s, 32'h0000_0008);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 mem_req/ack after reset", {30'd0, mem_req, periph_ack}, 32'd0);

    // R2/R3/R4/R6/R7: single memory copy, 16 bytes, word beats
    set_desc(32'h100, 32'h1, 32'h200, 32'h300, mk_cmd(16, 3, 3, 1, 0, 1, 1));
    for (int i = 0; i < 4; i++) exp_q.push_back({32'h300 + 32'(4*i), src_word(32'h200 + 32'(4*i))});
    rd_log.delete();
    start(32'h100);
    wait_stopped(s);
    chk("R6 R7 status after stop", s, 32'h0000_0009);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    chk("R2 fetch word 0", rd_log[0], 32'h100);
    chk("R2 fetch word 3", rd_log[3], 32'h10C);
    chk("R2 first data read after fetch", rd_log[4], 32'h200);
    chk("R3 all writes seen", 32'(exp_q.size()), 32'd0);
    csr_wr(2'd0, 32'h1);
    chk("R7 flag cleared by write-one", {31'd0, irq}, 32'd0);

    // R3/R4/R6: two-descriptor chain, half-word beats with fixed source
    set_desc(32'h140, 32'h160, 32'h240, 32'h340, mk_cmd(8, 2, 3, 0, 0, 1, 0));
    set_desc(32'h160, 32'h1, 32'h280, 32'h380, mk_cmd(8, 3, 3, 1, 0, 1, 1));
    for (int i = 0; i < 4; i++) exp_q.push_back({32'h340 + 32'(2*i), src_word(32'h240)});
    exp_q.push_back({32'h380, src_word(32'h280)});
    exp_q.push_back({32'h384, src_word(32'h284)});
    start(32'h140);
    wait_stopped(s);
    chk("R6 chain followed to stop", s, 32'h0000_0009);
    chk("R4 chain writes all seen", 32'(exp_q.size()), 32'd0);

    // R5/R9: paced transfer, 8-byte bursts
    set_desc(32'h1C0, 32'h1, 32'h2C0, 32'h3C0, mk_cmd(16, 3, 1, 1, 1, 1, 0));
    for (int i = 0; i < 4; i++) exp_q.push_back({32'h3C0 + 32'(4*i), src_word(32'h2C0)});
    wbase = wr_count; abase = ack_cnt;
    start(32'h1C0);
    repeat (30) @(negedge clk);
    chk("R5 no write without request", 32'(wr_count - wbase), 32'd0);
    csr_rd(2'd0, s);
    chk("R8 status running, request low", s, 32'h8000_0000);
    periph_req = 1'b1;
    csr_rd(2'd0, s);
    chk("R8 request level visible", s & 32'h0000_0108, 32'h0000_0100);
    @(negedge clk);
    while (!periph_ack) @(negedge clk);
    periph_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 one burst is two word beats", 32'(wr_count - wbase), 32'd2);
    csr_rd(2'd3, d);
    chk("R9 target mid-transfer", d, 32'h3C8);
    csr_rd(2'd2, d);
    chk("R9 source mid-transfer", d, 32'h2C0);
    periph_req = 1'b1;
    wait_stopped(s);
    periph_req = 1'b0;
    csr_rd(2'd0, s);
    chk("R5 paced chain stopped", s, 32'h0000_0009);
    chk("R5 ack pulses", 32'(ack_cnt - abase), 32'd2);
    chk("R5 paced writes all seen", 32'(exp_q.size()), 32'd0);

    // R8: clear run mid-transfer
    set_desc(32'h1E0, 32'h1, 32'h200, 32'h300, mk_cmd(64, 3, 3, 1, 0, 1, 1));
    for (int i = 0; i < 16; i++) exp_q.push_back({32'h300 + 32'(4*i), src_word(32'h200 + 32'(4*i))});
    wbase = wr_count;
    start(32'h1E0);
    while (wr_count - wbase < 3) @(negedge clk);
    csr_wr(2'd0, 32'h0);
    repeat (10) @(negedge clk);
    csr_rd(2'd0, s);
    chk("R8 stopped by run clear, no completion", s, 32'h0000_0008);
    chk("R8 transfer cut short", 32'(exp_q.size() > 0), 32'd1);
    exp_q.delete();
    abase = wr_count;
    repeat (20) @(negedge clk);
    chk("R8 no access after stop", 32'(wr_count - abase), 32'd0);

    // R10: bus error on source read
    set_desc(32'h1A0, 32'h1, 32'h2E0, 32'h3E0, mk_cmd(8, 3, 3, 1, 0, 1, 1));
    err_en = 1'b1; err_addr = 32'h2E0;
    wbase = wr_count;
    start(32'h1A0);
    wait_stopped(s);
    chk("R10 error flag, run cleared", s, 32'h0000_000A);
    chk("R10 irq on error", {31'd0, irq}, 32'd1);
    chk("R10 no write after error", 32'(wr_count - wbase), 32'd0);
    err_en = 1'b0;
    csr_wr(2'd0, 32'h2);
    chk("R10 error flag cleared", {31'd0, irq}, 32'd0);

    // R11: self-looping chain
    set_desc(32'h120, 32'h120, 32'h200, 32'h3E0, mk_cmd(4, 3, 3, 1, 0, 1, 1));
    sb_strict = 1'b0;
    wbase = wr_count;
    start(32'h120);
    while (wr_count - wbase < 3) @(negedge clk);
    csr_rd(2'd0, s);
    chk("R11 still running after laps", s, 32'h8000_0001);
    csr_wr(2'd0, 32'h0);
    wait_stopped(s);
    chk("R11 stops only on run clear", s, 32'h0000_0009);
    chk("R11 loop write addr", last_wr_addr, 32'h3E0);
    chk("R11 loop write data", last_wr_data, src_word(32'h200));
    sb_strict = 1'b1;

    // R12: zero-length descriptor
    set_desc(32'h1B0, 32'h1, 32'h200, 32'h300, mk_cmd(0, 3, 3, 1, 0, 1, 1));
    wbase = wr_count;
    rd_log.delete();
    start(32'h1B0);
    wait_stopped(s);
    chk("R12 zero length completes", s, 32'h0000_0009);
    chk("R12 only descriptor reads", 32'(rd_log.size()), 32'd4);
    chk("R12 no writes", 32'(wr_count - wbase), 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule